// File: doc/BRIEF.md
# Interrupt Priority and Acceptance Unit

This unit decides, at each instruction boundary of a small 8-bit CPU core, whether control passes to a handler, and which one. It sees a set of hardware request lines, each with its own priority level. It also sees a software break request and a table-call-0 request from instruction decode, and it keeps the global interrupt-enable flag and the break flag of the status word. When it accepts a source it gives that source a one-cycle acknowledge, presents the handler's vector address and updates the two status flags.

The break and table-call-0 paths share one vector address. The shared handler tells them apart by reading the break flag: a break sets it and a table-call-0 clears it. Accepting a hardware request or a break clears the global enable, so nothing else is taken. Software may write the enable back to one inside a handler, and that lets a later request nest. A return strobe restores both flags from a saved status value. Register saving, stack handling and instruction execution belong to the core.

Top module: `irq_accept_unit`

## Requirements
- R1: A hardware request is accepted only at a boundary strobe while the enable flag is 1. A break request is accepted at a boundary whatever the enable flag holds.
- R2: Among eligible hardware requests, the one whose 2-bit level (bits [2i+1:2i] of the level input for source i, larger value meaning more urgent) is highest wins.
- R3: Among eligible hardware requests of equal highest level, the lowest source index wins.
- R4: Acceptance order is: any eligible hardware request first, then table-call-0, then break last. At most one acknowledge is raised per boundary, as a single-cycle pulse in the cycle after the boundary edge. Sources that lose receive no acknowledge.
- R5: The vector output becomes 16'hFFFC - 2*i for hardware source i and 16'hFFDE for both break and table-call-0. It changes only on an acceptance and holds its value otherwise.
- R6: Accepting a break sets the break flag to 1 and the enable flag to 0.
- R7: Accepting a table-call-0 clears the break flag and leaves the enable flag unchanged.
- R8: Accepting a hardware request clears both the enable flag and the break flag.
- R9: A return strobe in a cycle without an acceptance loads the enable and break flags from the saved-status inputs.
- R10: An enable write strobe in a cycle with neither an acceptance nor a return strobe loads the enable flag from its data bit. An acceptance overrides both the return strobe and the write, and a return strobe overrides the write.
- R11: After reset the flags, acknowledges and vector are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary_i | input | 1 | Instruction-boundary strobe; acceptance is evaluated only here |
| irq_req_i | input | 8 | Pending hardware request lines |
| irq_lvl_i | input | 16 | Per-source 2-bit priority levels |
| brk_req_i | input | 1 | Software break request |
| tcall0_req_i | input | 1 | Table-call-0 request |
| ie_set_i | input | 1 | Software write strobe for the enable flag |
| ie_wdata_i | input | 1 | Value written to the enable flag |
| reti_i | input | 1 | Return-from-interrupt strobe |
| saved_ie_i | input | 1 | Saved enable flag restored on return |
| saved_brk_i | input | 1 | Saved break flag restored on return |
| irq_ack_o | output | 8 | One-hot acknowledge to the winning hardware source |
| brk_ack_o | output | 1 | Acknowledge of the break request |
| tcall0_ack_o | output | 1 | Acknowledge of the table-call-0 request |
| vec_o | output | 16 | Handler vector address |
| ie_o | output | 1 | Global interrupt-enable flag |
| brk_flag_o | output | 1 | Break flag of the status word |

## Verification
An acceptance at a boundary can land in the same cycle as a return strobe or an enable write. Each of these wants the enable flag, so the overlap decides whether a nested request gets in. The bench drives boundary, return and write strobes at random so that they often coincide. It also forces the overlap directly: a hardware acceptance together with a write of one, and a break together with a return. Each cycle the flags are compared with a model that applies the override order from the requirements.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

  typedef enum logic [1:0] {
    WIN_NONE  = 2'd0,
    WIN_HW    = 2'd1,
    WIN_TCALL = 2'd2,
    WIN_BRK   = 2'd3
  } win_e;

  // Vector slot of hardware source idx, counting down from the top slot
  function automatic logic [31:0] hw_vector(logic [31:0] top, int idx);
    return top - 32'(2 * idx);
  endfunction

endpackage

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 2,
  parameter int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]       req,
  input  logic [N_SRC*LVL_W-1:0] lvl,
  output logic                   found,
  output logic [IDX_W-1:0]       idx
);

  logic [LVL_W-1:0] best_lvl;

  // Strictly-greater compare keeps the lowest index among equal levels
  always_comb begin
    found    = 1'b0;
    idx      = '0;
    best_lvl = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req[i] && (!found || (lvl[i*LVL_W +: LVL_W] > best_lvl))) begin
        found    = 1'b1;
        idx      = IDX_W'(i);
        best_lvl = lvl[i*LVL_W +: LVL_W];
      end
    end
  end

endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_accept_pkg::*;
#(
  parameter int          N_SRC  = 8,
  parameter int          IDX_W  = $clog2(N_SRC),
  parameter int          ADDR_W = 16,
  parameter logic [31:0] HW_TOP = 32'h0000_FFFC,
  parameter logic [31:0] SW_VEC = 32'h0000_FFDE
) (
  input  logic              boundary,
  input  logic              hw_found,
  input  logic [IDX_W-1:0]  hw_idx,
  input  logic              tcall_req,
  input  logic              brk_req,
  output win_e              win,
  output logic [ADDR_W-1:0] vec_d
);

  always_comb begin
    win = WIN_NONE;
    if (boundary) begin
      if (hw_found)       win = WIN_HW;
      else if (tcall_req) win = WIN_TCALL;
      else if (brk_req)   win = WIN_BRK;
    end
  end

  always_comb begin
    if (win == WIN_HW) vec_d = ADDR_W'(hw_vector(HW_TOP, int'(hw_idx)));
    else               vec_d = ADDR_W'(SW_VEC);
  end

endmodule

// File: rtl/irq_status_flags.sv
module irq_status_flags
  import irq_accept_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  win_e win,
  input  logic reti,
  input  logic saved_ie,
  input  logic saved_brk,
  input  logic ie_set,
  input  logic ie_wdata,
  output logic ie_q,
  output logic brk_q
);

  logic ie_d, brk_d;

  always_comb begin
    ie_d  = ie_q;
    brk_d = brk_q;
    unique case (win)
      WIN_HW:    begin ie_d = 1'b0; brk_d = 1'b0; end
      WIN_BRK:   begin ie_d = 1'b0; brk_d = 1'b1; end
      WIN_TCALL: begin brk_d = 1'b0; end
      default: begin
        if (reti) begin
          ie_d  = saved_ie;
          brk_d = saved_brk;
        end else if (ie_set) begin
          ie_d = ie_wdata;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      brk_q <= 1'b0;
    end else begin
      ie_q  <= ie_d;
      brk_q <= brk_d;
    end
  end

endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import irq_accept_pkg::*;
#(
  parameter int          N_SRC  = 8,
  parameter int          LVL_W  = 2,
  parameter int          ADDR_W = 16,
  parameter logic [31:0] HW_TOP = 32'h0000_FFFC,
  parameter logic [31:0] SW_VEC = 32'h0000_FFDE
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   boundary_i,
  input  logic [N_SRC-1:0]       irq_req_i,
  input  logic [N_SRC*LVL_W-1:0] irq_lvl_i,
  input  logic                   brk_req_i,
  input  logic                   tcall0_req_i,
  input  logic                   ie_set_i,
  input  logic                   ie_wdata_i,
  input  logic                   reti_i,
  input  logic                   saved_ie_i,
  input  logic                   saved_brk_i,
  output logic [N_SRC-1:0]       irq_ack_o,
  output logic                   brk_ack_o,
  output logic                   tcall0_ack_o,
  output logic [ADDR_W-1:0]      vec_o,
  output logic                   ie_o,
  output logic                   brk_flag_o
);

  localparam int IDX_W = $clog2(N_SRC);

  logic [N_SRC-1:0]  eligible;
  logic              hw_found;
  logic [IDX_W-1:0]  hw_idx;
  win_e              win;
  logic [ADDR_W-1:0] vec_d;
  logic [N_SRC-1:0]  ack_d;
  logic              vec_en;

  // Hardware lines compete only while the enable flag is set
  assign eligible = irq_req_i & {N_SRC{ie_o}};

  irq_level_arbiter #(.N_SRC(N_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_arb (
    .req   (eligible),
    .lvl   (irq_lvl_i),
    .found (hw_found),
    .idx   (hw_idx)
  );

  irq_accept_ctrl #(
    .N_SRC(N_SRC), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
    .HW_TOP(HW_TOP), .SW_VEC(SW_VEC)
  ) u_ctrl (
    .boundary  (boundary_i),
    .hw_found  (hw_found),
    .hw_idx    (hw_idx),
    .tcall_req (tcall0_req_i),
    .brk_req   (brk_req_i),
    .win       (win),
    .vec_d     (vec_d)
  );

  irq_status_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .win       (win),
    .reti      (reti_i),
    .saved_ie  (saved_ie_i),
    .saved_brk (saved_brk_i),
    .ie_set    (ie_set_i),
    .ie_wdata  (ie_wdata_i),
    .ie_q      (ie_o),
    .brk_q     (brk_flag_o)
  );

  always_comb begin
    ack_d = '0;
    if (win == WIN_HW) ack_d[hw_idx] = 1'b1;
  end

  assign vec_en = (win != WIN_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_ack_o    <= '0;
      brk_ack_o    <= 1'b0;
      tcall0_ack_o <= 1'b0;
    end else begin
      irq_ack_o    <= ack_d;
      brk_ack_o    <= (win == WIN_BRK);
      tcall0_ack_o <= (win == WIN_TCALL);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_o <= '0;
    else if (vec_en) vec_o <= vec_d;
  end

endmodule

// File: rtl/irq_accept_checker.sv
module irq_accept_checker #(
  parameter int          N_SRC  = 8,
  parameter int          ADDR_W = 16,
  parameter logic [31:0] SW_VEC = 32'h0000_FFDE
) (
  input logic              clk,
  input logic              rst_n,
  input logic              boundary_i,
  input logic              reti_i,
  input logic              saved_ie_i,
  input logic              saved_brk_i,
  input logic [N_SRC-1:0]  irq_ack_o,
  input logic              brk_ack_o,
  input logic              tcall0_ack_o,
  input logic [ADDR_W-1:0] vec_o,
  input logic              ie_o,
  input logic              brk_flag_o
);

  logic any_ack;
  assign any_ack = (|irq_ack_o) | brk_ack_o | tcall0_ack_o;

  assert_hw_needs_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack_o) |-> ($past(ie_o) && $past(boundary_i)));

  assert_single_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_ack_o, brk_ack_o, tcall0_ack_o}));

  assert_ack_after_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    any_ack |-> $past(boundary_i));

  assert_shared_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_ack_o || tcall0_ack_o) |-> (vec_o == ADDR_W'(SW_VEC)));

  assert_brk_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_ack_o |-> (brk_flag_o && !ie_o));

  assert_tcall_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tcall0_ack_o |-> (!brk_flag_o && (ie_o == $past(ie_o))));

  assert_hw_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack_o) |-> (!ie_o && !brk_flag_o));

  assert_reti_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !boundary_i) |=> ((ie_o == $past(saved_ie_i)) && (brk_flag_o == $past(saved_brk_i))));

endmodule

bind irq_accept_unit irq_accept_checker #(
  .N_SRC(N_SRC), .ADDR_W(ADDR_W), .SW_VEC(SW_VEC)
) u_irq_accept_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .boundary_i   (boundary_i),
  .reti_i       (reti_i),
  .saved_ie_i   (saved_ie_i),
  .saved_brk_i  (saved_brk_i),
  .irq_ack_o    (irq_ack_o),
  .brk_ack_o    (brk_ack_o),
  .tcall0_ack_o (tcall0_ack_o),
  .vec_o        (vec_o),
  .ie_o         (ie_o),
  .brk_flag_o   (brk_flag_o)
);

// File: tb/irq_accept_unit_test.sv
module irq_accept_unit_test;

  localparam int PERIOD = 10;
  localparam int N      = 8;
  localparam int LW     = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          boundary_i;
  logic [N-1:0]  irq_req_i;
  logic [N*LW-1:0] irq_lvl_i;
  logic          brk_req_i, tcall0_req_i, ie_set_i, ie_wdata_i;
  logic          reti_i, saved_ie_i, saved_brk_i;
  logic [N-1:0]  irq_ack_o;
  logic          brk_ack_o, tcall0_ack_o, ie_o, brk_flag_o;
  logic [15:0]   vec_o;

  int n_tests = 0;
  int n_fail  = 0;

  // Reference model state
  logic [N-1:0] m_ack;
  logic         m_abrk, m_atc, m_ie, m_brk;
  logic [15:0]  m_vec;

  always #(PERIOD/2) clk = ~clk;

  irq_accept_unit uut (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i),
    .irq_req_i(irq_req_i), .irq_lvl_i(irq_lvl_i),
    .brk_req_i(brk_req_i), .tcall0_req_i(tcall0_req_i),
    .ie_set_i(ie_set_i), .ie_wdata_i(ie_wdata_i),
    .reti_i(reti_i), .saved_ie_i(saved_ie_i), .saved_brk_i(saved_brk_i),
    .irq_ack_o(irq_ack_o), .brk_ack_o(brk_ack_o), .tcall0_ack_o(tcall0_ack_o),
    .vec_o(vec_o), .ie_o(ie_o), .brk_flag_o(brk_flag_o)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check(irq_ack_o == m_ack, tag, "irq_ack", 32'(irq_ack_o), 32'(m_ack));
    check(brk_ack_o == m_abrk && tcall0_ack_o == m_atc, tag, "sw_ack",
          {30'd0, brk_ack_o, tcall0_ack_o}, {30'd0, m_abrk, m_atc});
    check(vec_o == m_vec, tag, "vector", 32'(vec_o), 32'(m_vec));
    check(ie_o == m_ie && brk_flag_o == m_brk, tag, "flags ie/brk",
          {30'd0, ie_o, brk_flag_o}, {30'd0, m_ie, m_brk});
  endtask

  function automatic logic [1:0] lvl_of(int i);
    return irq_lvl_i[i*LW +: LW];
  endfunction

  // Apply one clock edge to the model from the current inputs (R1..R10)
  task automatic model_edge();
    int best = -1;
    for (int i = 0; i < N; i++)
      if (irq_req_i[i] && m_ie && (best < 0 || lvl_of(i) > lvl_of(best))) best = i;
    m_ack = '0; m_abrk = 1'b0; m_atc = 1'b0;
    if (boundary_i && best >= 0) begin
      m_ack[best] = 1'b1; m_vec = 16'hFFFC - 16'(2*best); m_ie = 1'b0; m_brk = 1'b0;
    end else if (boundary_i && tcall0_req_i) begin
      m_atc = 1'b1; m_vec = 16'hFFDE; m_brk = 1'b0;
    end else if (boundary_i && brk_req_i) begin
      m_abrk = 1'b1; m_vec = 16'hFFDE; m_ie = 1'b0; m_brk = 1'b1;
    end else if (reti_i) begin
      m_ie = saved_ie_i; m_brk = saved_brk_i;
    end else if (ie_set_i) begin
      m_ie = ie_wdata_i;
    end
  endtask

  task automatic step(input string tag);
    model_edge();
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic idle();
    boundary_i = 0; irq_req_i = '0; brk_req_i = 0; tcall0_req_i = 0;
    ie_set_i = 0; ie_wdata_i = 0; reti_i = 0; saved_ie_i = 0; saved_brk_i = 0;
  endtask

  task automatic set_ie(input logic v);
    idle(); ie_set_i = 1; ie_wdata_i = v; step("R10");
    idle();
  endtask

  initial begin
    #(PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2468));
    idle();
    irq_lvl_i = '0;
    rst_n = 1'b0;
    m_ack = '0; m_abrk = 0; m_atc = 0; m_ie = 0; m_brk = 0; m_vec = '0;
    repeat (3) @(negedge clk);
    compare_all("R11");  // reset state
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R11");

    // R1: enable clear, hardware request ignored, break still accepted
    irq_req_i = 8'h10; brk_req_i = 1; boundary_i = 1;
    step("R1");
    idle(); step("R1");

    // R2: higher level wins over lower index
    set_ie(1);
    irq_lvl_i = '0; irq_lvl_i[1*LW +: LW] = 2'd1; irq_lvl_i[6*LW +: LW] = 2'd3;
    irq_req_i = 8'h42; boundary_i = 1; step("R2");
    idle(); step("R8");  // enable cleared: no acceptance while request stays
    irq_req_i = 8'h42; boundary_i = 1; step("R1");

    // R3: equal levels, lowest index wins
    set_ie(1);
    irq_lvl_i = '0; irq_lvl_i[2*LW +: LW] = 2'd2; irq_lvl_i[5*LW +: LW] = 2'd2;
    irq_req_i = 8'h24; boundary_i = 1; step("R3");

    // R4/R7: tcall0 beats break; enable unchanged
    idle(); set_ie(1);
    tcall0_req_i = 1; brk_req_i = 1; boundary_i = 1; step("R7");
    idle(); step("R4");
    // R4: hardware beats tcall0
    irq_req_i = 8'h01; tcall0_req_i = 1; boundary_i = 1; step("R4");

    // R10: nesting, enable rewritten inside handler lets next request in
    set_ie(1);
    irq_req_i = 8'h80; boundary_i = 1; step("R10");
    idle(); ie_set_i = 1; ie_wdata_i = 1; step("R10");
    idle(); irq_req_i = 8'h08; boundary_i = 1; step("R10");
    // R10: acceptance and write in the same cycle, acceptance wins
    set_ie(1);
    irq_req_i = 8'h02; boundary_i = 1; ie_set_i = 1; ie_wdata_i = 1; step("R10");
    // R9: return restores flags; return beats write
    idle(); reti_i = 1; saved_ie_i = 1; saved_brk_i = 1; ie_set_i = 1; ie_wdata_i = 0;
    step("R9");
    // R9/R6: break with return in same cycle, break wins
    idle(); brk_req_i = 1; boundary_i = 1; reti_i = 1; saved_ie_i = 1; saved_brk_i = 0;
    step("R6");
    // R5: vector holds without acceptance
    idle(); repeat (3) step("R5");

    // Random phase
    for (int c = 0; c < 4000; c++) begin
      boundary_i   = ($urandom % 2) == 0;
      irq_req_i    = N'($urandom) & N'($urandom);
      irq_lvl_i    = (N*LW)'($urandom);
      brk_req_i    = ($urandom % 8) == 0;
      tcall0_req_i = ($urandom % 12) == 0;
      reti_i       = ($urandom % 8) == 0;
      saved_ie_i   = 1'($urandom);
      saved_brk_i  = 1'($urandom);
      ie_set_i     = ($urandom % 4) == 0;
      ie_wdata_i   = ($urandom % 4) != 0;
      step("R2 R3 R4 R5");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule